// File: doc/BRIEF.md
# Clock Mode and Standby Controller

This block decides, cycle by cycle, whether the CPU and the peripherals of a small microcontroller get a clock edge. It runs on one fast clock. Each cycle of that clock stands for one period of the main oscillator. A synchronized one-cycle pulse, `sub_tick`, marks each period of the slow subsystem oscillator. The block turns these into a CPU clock-enable, a peripheral clock-enable and a separate subclock enable for the timekeeping and display group. It also drives run controls for both oscillators and reports standby status.

Software sets up the block through four byte registers on a simple write port, and the same registers can be read back. The registers pick the main-clock speed, the CPU clock source and the subclock rate. They also stop either oscillator and store a feedback-resistor flag. HALT and STOP requests and a wake-up input move the block between running and standby. The register logic refuses any combination that would leave the CPU with no clock: a refused write leaves the register unchanged.

Top module: `clkmode_ctrl`

Register map (address: fields):
- 0 `clkctl`: bit 7 main-oscillator stop, bit 1 slow main mode, bits 6..2 and 0 stored only. Reset value 0x02.
- 1 `oscmode`: bit 0 subclock-oscillator stop, bit 1 feedback-resistor disable. Reset value 0x00.
- 2 `srcsel`: bit 4 selects the subclock as the CPU source. Reset value 0x00.
- 3 `subrate`: bit 0 selects the x4 subclock rate. Reset value 0x00.

Bits not listed for addresses 1 to 3 read as 0.

## Requirements
- R1: While `rst_n` is low, `main_osc_run` and `cpu_ce` are 0. After reset the registers read 0x02, 0x00, 0x00 and 0x00 at addresses 0 to 3, and the CPU runs from the main clock in slow mode.
- R2: On the main clock, with `clkctl` bit 1 = 0, `cpu_ce` pulses once every FAST_DIV cycles. With bit 1 = 1 it pulses once every SLOW_DIV cycles.
- R3: With `srcsel` bit 4 = 1, `cpu_ce` pulses on every SUB_DIV-th `sub_tick`. With `subrate` bit 0 = 1 as well, it pulses on every `sub_tick`.
- R4: A write of 1 to `clkctl` bit 7 takes effect only while `srcsel` bit 4 is 1. Otherwise bit 7 is stored as 0. While bit 7 is 1, `main_osc_run` and `periph_ce` are 0.
- R5: The block refuses three writes and leaves the register unchanged: clearing `srcsel` bit 4 while the main oscillator is stopped, setting `srcsel` bit 4 while the subclock oscillator is stopped, and any change of `oscmode` bit 0 while the subclock is selected.
- R6: `oscmode` bit 0 = 1 drives `sub_osc_run` to 0 and masks `sub_tick`. `oscmode` bit 1 is stored and driven on `fb_res_off`.
- R7: `halt_req` during normal running enters HALT with either clock source. HALT sets `halted` and holds `cpu_ce` at 0, while `periph_ce` keeps following the main oscillator.
- R8: `stop_req` enters STOP only when the main clock is the CPU source. STOP sets `stopped` and drives `main_osc_run`, `periph_ce` and `cpu_ce` to 0. With the subclock selected, `stop_req` has no effect.
- R9: `sub_periph_ce` pulses with every `sub_tick` while the subclock oscillator runs, in normal running, HALT and STOP alike.
- R10: `wake` leaves HALT on the next cycle. From STOP, `wake` restarts the main oscillator and holds `cpu_ce` and `periph_ce` at 0 for SETTLE_TICKS cycles. The first `cpu_ce` then comes SETTLE_TICKS plus one divider period after the cycle in which `wake` was sampled.
- R11: When `halt_req` and `stop_req` arrive together and STOP is allowed, STOP wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one cycle per main-oscillator period |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle pulse per subclock period, already synchronized |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| halt_req | input | 1 | HALT entry request |
| stop_req | input | 1 | STOP entry request |
| wake | input | 1 | Wake-up from HALT or STOP |
| cpu_ce | output | 1 | CPU clock-enable |
| periph_ce | output | 1 | Peripheral clock-enable from the main oscillator |
| sub_periph_ce | output | 1 | Subclock enable for the timer, watch and display group |
| main_osc_run | output | 1 | Main oscillator run control |
| sub_osc_run | output | 1 | Subclock oscillator run control |
| fb_res_off | output | 1 | Feedback-resistor disable flag |
| halted | output | 1 | HALT state |
| stopped | output | 1 | STOP state |

## Verification
The bench keeps the default dividers (2, 8 and 4) and lowers SETTLE_TICKS from 1024 to 16. At 16 the whole STOP exit fits in a short window, so the bench can count the exact delay to the first `cpu_ce`, and no register behaviour is lost by the smaller value. A `sub_tick` every five clocks makes the subclock periods of 20 and 5 cycles easy to tell apart from the main-clock periods of 2 and 8.

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
  parameter int FAST_DIV     = 2,
  parameter int SLOW_DIV     = 8,
  parameter int SUB_DIV      = 4,
  parameter int SETTLE_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       halt_req,
  input  logic       stop_req,
  input  logic       wake,
  output logic       cpu_ce,
  output logic       periph_ce,
  output logic       sub_periph_ce,
  output logic       main_osc_run,
  output logic       sub_osc_run,
  output logic       fb_res_off,
  output logic       halted,
  output logic       stopped
);
  localparam int DW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam int SW = (SUB_DIV > 2) ? $clog2(SUB_DIV) : 1;
  localparam int CW = $clog2(SETTLE_TICKS + 1);
  localparam logic [DW-1:0] FAST_LIM = DW'(FAST_DIV - 1);
  localparam logic [DW-1:0] SLOW_LIM = DW'(SLOW_DIV - 1);
  localparam logic [SW-1:0] SUB_LIM  = SW'(SUB_DIV - 1);
  localparam logic [CW-1:0] SET_LIM  = CW'(SETTLE_TICKS - 1);

  typedef enum logic [1:0] {S_RUN, S_HALT, S_STOP, S_SETTLE} mode_t;

  mode_t         state;
  logic [6:0]    ctl;
  logic          mstop, sstop, fb, use_sub, x4;
  logic [DW-1:0] div;
  logic [SW-1:0] scnt;
  logic [CW-1:0] settle;
  logic          sub_live, main_hit, sub_hit;
  logic [DW-1:0] lim;

  assign sub_live      = sub_tick & ~sstop;
  assign lim           = ctl[1] ? SLOW_LIM : FAST_LIM;
  assign main_hit      = div >= lim;
  assign sub_hit       = sub_live & (x4 | (scnt == SUB_LIM));
  assign main_osc_run  = rst_n & ~mstop & (state != S_STOP);
  assign sub_osc_run   = ~sstop;
  assign periph_ce     = main_osc_run & (state != S_SETTLE);
  assign sub_periph_ce = sub_live;
  assign fb_res_off    = fb;
  assign halted        = state == S_HALT;
  assign stopped       = state == S_STOP;
  assign cpu_ce        = (state == S_RUN) & (use_sub ? sub_hit : (main_hit & main_osc_run));

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {mstop, ctl};
      2'd1:    rd_data = {6'd0, fb, sstop};
      2'd2:    rd_data = {3'd0, use_sub, 4'd0};
      default: rd_data = {7'd0, x4};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= 7'h02;
      mstop   <= 1'b0;
      sstop   <= 1'b0;
      fb      <= 1'b0;
      use_sub <= 1'b0;
      x4      <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin
          ctl   <= wr_data[6:0];
          mstop <= wr_data[7] & use_sub;
        end
        2'd1: begin
          fb <= wr_data[1];
          if (!use_sub) sstop <= wr_data[0];
        end
        2'd2: if (wr_data[4] ? !sstop : !mstop) use_sub <= wr_data[4];
        default: x4 <= wr_data[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_RUN;
      settle <= '0;
    end else begin
      case (state)
        S_RUN: begin
          if (stop_req && !use_sub) state <= S_STOP;
          else if (halt_req)        state <= S_HALT;
        end
        S_HALT: if (wake) state <= S_RUN;
        S_STOP: begin
          settle <= '0;
          if (wake) state <= S_SETTLE;
        end
        default: begin
          if (settle == SET_LIM) state <= S_RUN;
          else settle <= settle + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div  <= '0;
      scnt <= '0;
    end else begin
      if (state != S_RUN || use_sub) div <= '0;
      else div <= main_hit ? '0 : div + 1'b1;
      if (state != S_RUN || !use_sub) scnt <= '0;
      else if (sub_live) scnt <= (x4 || scnt == SUB_LIM) ? '0 : scnt + 1'b1;
    end
  end
endmodule

module clkmode_ctrl_sva (
  input logic clk,
  input logic rst_n,
  input logic cpu_ce,
  input logic periph_ce,
  input logic main_osc_run,
  input logic sub_osc_run,
  input logic halted,
  input logic stopped,
  input logic wake,
  input logic mstop,
  input logic use_sub
);
  always_comb begin
    if (!rst_n) p_osc_held_r1: assert (!main_osc_run && !cpu_ce);
  end

  p_mstop_on_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mstop |-> use_sub);
  p_periph_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_run |-> !periph_ce);
  p_sub_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    use_sub |-> sub_osc_run);
  p_halt_no_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !cpu_ce);
  p_stop_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> !$past(use_sub));
  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!main_osc_run && !cpu_ce && !periph_ce));
  p_halt_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && wake) |=> !halted);
endmodule

bind clkmode_ctrl clkmode_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .periph_ce(periph_ce),
  .main_osc_run(main_osc_run), .sub_osc_run(sub_osc_run), .halted(halted),
  .stopped(stopped), .wake(wake), .mstop(mstop), .use_sub(use_sub)
);

// File: tb/clkmode_ctrl_bench.sv
module clkmode_ctrl_bench;
  localparam int SETTLE = 16;
  localparam int SUB_P  = 5;

  logic clk = 0, rst_n = 0, sub_tick = 0, wr_en = 0, halt_req = 0, stop_req = 0, wake = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic cpu_ce, periph_ce, sub_periph_ce, main_osc_run, sub_osc_run, fb_res_off, halted, stopped;
  int total = 0, bad = 0;
  logic [7:0] m_ctl = 8'h02;
  logic m_sstop = 0, m_fb = 0, m_sub = 0, m_x4 = 0;

  clkmode_ctrl #(.FAST_DIV(2), .SLOW_DIV(8), .SUB_DIV(4), .SETTLE_TICKS(SETTLE)) u_clkmode_ctrl (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .halt_req(halt_req),
    .stop_req(stop_req), .wake(wake), .cpu_ce(cpu_ce), .periph_ce(periph_ce),
    .sub_periph_ce(sub_periph_ce), .main_osc_run(main_osc_run), .sub_osc_run(sub_osc_run),
    .fb_res_off(fb_res_off), .halted(halted), .stopped(stopped));

  always #2 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      #1 sub_tick = (c == SUB_P - 1);
      c = (c + 1) % SUB_P;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    case (a)
      0: return m_ctl;
      1: return {6'd0, m_fb, m_sstop};
      2: return {3'd0, m_sub, 4'd0};
      default: return {7'd0, m_x4};
    endcase
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'(a); wr_data = d;
    case (a)
      0: m_ctl = {d[7] & m_sub, d[6:0]};
      1: begin m_fb = d[1]; if (!m_sub) m_sstop = d[0]; end
      2: if (d[4] ? !m_sstop : !m_ctl[7]) m_sub = d[4];
      default: m_x4 = d[0];
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input int a);
    rd_addr = 2'(a);
    #1;
    chk(req, int'(rd_data), int'(exp_rd(a)));
  endtask

  task automatic period(output int p);
    int c = 0;
    p = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (cpu_ce) break;
    end
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      c++;
      if (cpu_ce) begin p = c; break; end
    end
  endtask

  task automatic per_chk(input string req, input int exp);
    int p;
    period(p);
    period(p);
    chk(req, p, exp);
  endtask

  task automatic pulse(input logic h, input logic s, input logic w);
    @(negedge clk);
    halt_req = h; stop_req = s; wake = w;
    @(negedge clk);
    halt_req = 0; stop_req = 0; wake = 0;
  endtask

  task automatic quiet_window(input string req, input int n, output int ce, output int subs);
    ce = 0; subs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpu_ce) ce++;
      if (sub_periph_ce) subs++;
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ce, subs, k;
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R1 osc held in reset", int'(main_osc_run), 0);
    chk("R1 cpu_ce in reset", int'(cpu_ce), 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) rd_chk("R1 reset readback", a);
    chk("R1 main runs", int'(main_osc_run), 1);
    per_chk("R1 slow default period", 8);

    wr(0, 8'h00); per_chk("R2 fast period", 2);
    wr(0, 8'h02); per_chk("R2 slow period", 8);

    wr(2, 8'h10); rd_chk("R3 srcsel set", 2);
    per_chk("R3 sub period", 4 * SUB_P);
    wr(3, 8'h01); per_chk("R3 x4 period", SUB_P);
    wr(3, 8'h00);

    wr(2, 8'h00); wr(0, 8'h82);
    rd_chk("R4 main stop refused on main", 0);
    chk("R4 main still runs", int'(main_osc_run), 1);
    wr(2, 8'h10); wr(0, 8'h82);
    rd_chk("R4 main stop accepted on sub", 0);
    chk("R4 main osc off", int'(main_osc_run), 0);
    chk("R4 periph off", int'(periph_ce), 0);
    wr(2, 8'h00); rd_chk("R5 source kept while main stopped", 2);
    wr(1, 8'h01); rd_chk("R5 sub stop refused while selected", 1);
    chk("R5 sub osc runs", int'(sub_osc_run), 1);
    per_chk("R4 cpu on sub with main stopped", 4 * SUB_P);
    wr(0, 8'h02); wr(2, 8'h00);
    chk("R4 main restarts", int'(main_osc_run), 1);

    wr(1, 8'h01);
    chk("R6 sub osc off", int'(sub_osc_run), 0);
    quiet_window("R6", 20, ce, subs);
    chk("R6 sub ticks masked", subs, 0);
    wr(2, 8'h10); rd_chk("R5 select of stopped sub refused", 2);
    wr(1, 8'h02);
    chk("R6 fb flag out", int'(fb_res_off), 1);
    chk("R6 sub osc back", int'(sub_osc_run), 1);
    wr(1, 8'h00);

    wr(2, 8'h10);
    pulse(0, 1, 0);
    chk("R8 stop refused on sub", int'(stopped), 0);
    per_chk("R8 cpu keeps running on sub", 4 * SUB_P);
    pulse(1, 0, 0);
    chk("R7 halt on sub", int'(halted), 1);
    quiet_window("R7", 20, ce, subs);
    chk("R7 no cpu_ce in halt", ce, 0);
    chk("R9 sub feed in halt", subs, 4);
    chk("R7 periph runs in halt", int'(periph_ce), 1);
    pulse(0, 0, 1);
    chk("R10 halt exit", int'(halted), 0);
    per_chk("R10 cpu resumes after halt", 4 * SUB_P);

    wr(2, 8'h00);
    pulse(0, 1, 0);
    chk("R8 stop on main", int'(stopped), 1);
    chk("R8 main osc off", int'(main_osc_run), 0);
    chk("R8 periph off", int'(periph_ce), 0);
    quiet_window("R8", 20, ce, subs);
    chk("R8 no cpu_ce in stop", ce, 0);
    chk("R9 sub feed in stop", subs, 4);
    @(negedge clk) wake = 1;
    k = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      wake = 0;
      k++;
      if (k == 2) begin
        chk("R10 osc restarts on wake", int'(main_osc_run), 1);
        chk("R10 periph held while settling", int'(periph_ce), 0);
      end
      if (cpu_ce) break;
    end
    chk("R10 settle delay", k, SETTLE + 8);
    chk("R10 stop exit", int'(stopped), 0);

    pulse(1, 1, 0);
    chk("R11 stop wins", int'(stopped), 1);
    chk("R11 not halted", int'(halted), 0);
    pulse(0, 0, 1);
    repeat (SETTLE + 2) @(negedge clk);

    for (int n = 0; n < 300; n++) begin
      int a;
      logic [7:0] d;
      a = $urandom_range(0, 3);
      d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) d[7] = 1;
      wr(a, d);
      rd_chk("R4 R5 random readback", a);
      chk("R4 random main osc", int'(main_osc_run), int'(!m_ctl[7]));
      chk("R6 random sub osc", int'(sub_osc_run), int'(!m_sstop));
      chk("R6 random fb", int'(fb_res_off), int'(m_fb));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule